// File: doc/BRIEF.md
# Fluctuating Background Current Generator

This block gives every neuron of a spiking network simulation a noisy background input current, one update per neuron per simulation step. Each neuron keeps its own current value in a private state memory. On every update strobe the block reads that neuron's value and moves it part of the way back toward a mean. The mean is chosen by the neuron's cell class. It then adds a scaled uniform random term, writes the result back and presents it on the output with a valid strobe.

The noise comes from a 32-bit Galois LFSR. The LFSR steps exactly once per neuron update, so a given seed and a given update order always give the same current sequence. The decay factor, the noise amplitude, the three class means and the LFSR seed are held in registers that software can write. All values are signed 16.16 fixed point, which means a raw value of 65536 stands for 1.0.

The sequencer that walks the neurons once per millisecond drives the update strobe, the neuron index and the class code. The synapse logic that consumes the current takes it from the output port.

Top module: `bg_current_gen`

## Requirements
- R1: While rst_n is low, and after it is released, cur_o reads 0 and cur_vld_o reads 0 until the first update. Every neuron's stored current resets to 0, and the LFSR resets to the SEED parameter.
- R2: An update strobe on upd_i at a clock edge makes cur_vld_o high for exactly the following cycle, carrying the new current. Without a strobe, cur_vld_o is low and cur_o keeps its last value.
- R3: The new current equals m + ((k*(s - m)) >>> 16) + ((g*u) >>> 16), truncated to 32 bits. Here s is the neuron's stored current, m is the class mean, k is the decay register and g is the amplitude register. Both shifts are arithmetic and all values are signed 16.16.
- R4: Class code 0 (pyramidal) and class code 1 (basket) select means that default to 183501, which is 2.8. Class code 2 (non-basket) selects a mean that defaults to 32768, which is 0.5. Class code 3 selects a mean of 0.
- R5: The noise sample u is the upper 16 LFSR bits, zero-extended, minus 32768. The sample is taken from the LFSR value before the update advances it.
- R6: The LFSR steps as next = (l >> 1) XOR (l[0] ? 32'h80200003 : 0). It advances exactly once on each update and never on any other cycle.
- R7: Each neuron index has its own stored current. An update of one neuron leaves every other neuron's value unchanged.
- R8: A write with cfg_we_i loads cfg_data_i into the register selected by cfg_addr_i: 0 is decay (default 58982, about 0.9), 1 is amplitude (default 55706, about 0.85), 2 is the seed, and 4, 5 and 6 are the means of classes 0, 1 and 2. Other addresses are ignored.
- R9: A seed write loads the LFSR. A seed value of 0 is replaced by 1, so the LFSR never holds 0.
- R10: A configuration write in the same cycle as an update takes effect only for later updates, and the update uses the old values. A seed write in that cycle overrides the LFSR advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_i | input | 1 | Update strobe for one neuron |
| nidx_i | input | $clog2(NEURONS) | Neuron index to update |
| ncls_i | input | 2 | Cell class code of that neuron |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 3 | Configuration register select |
| cfg_data_i | input | 32 | Configuration write data |
| cur_o | output | 32 | Updated current, signed 16.16 |
| cur_vld_o | output | 1 | Marks cur_o as freshly updated |

## Verification
The hardest case to reach from the ports is a configuration write that arrives in the same cycle as an update. A seed write that collides with an LFSR advance is the sharpest form of it. The bench raises the write enable and the update strobe on the same falling edge. It checks that the current produced uses the old decay factor. A later run with decay and amplitude set to zero and to one shows that the reloaded LFSR holds exactly the written seed, or 1 for a zero seed. An update sequence that revisits indices between updates of other neurons exposes any leak between per-neuron states.

// File: rtl/bg_current_gen.sv
module bg_current_gen #(
  parameter int NEURONS = 16,
  parameter logic [31:0] SEED = 32'hACE1_2468,
  localparam int IW = $clog2(NEURONS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_i,
  input  logic [IW-1:0] nidx_i,
  input  logic [1:0]    ncls_i,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_addr_i,
  input  logic [31:0]   cfg_data_i,
  output logic [31:0]   cur_o,
  output logic          cur_vld_o
);
  localparam logic [31:0] TAPS = 32'h8020_0003;

  logic signed [31:0] decay_q, amp_q;
  logic signed [31:0] mean_q [3];
  logic        [31:0] lfsr_q;
  logic signed [31:0] st_q [NEURONS];

  logic signed [31:0] mean_sel;
  logic signed [63:0] diff, pull, noise, nxt;
  logic        [31:0] lfsr_nx;
  logic               seed_wr;

  assign mean_sel = (ncls_i == 2'd3) ? 32'sd0 : mean_q[ncls_i];
  assign diff     = 64'(st_q[nidx_i]) - 64'(mean_sel);
  assign pull     = (64'(decay_q) * diff) >>> 16;
  assign noise    = (64'(amp_q) * (64'($signed({1'b0, lfsr_q[31:16]})) - 64'sd32768)) >>> 16;
  assign nxt      = 64'(mean_sel) + pull + noise;
  assign lfsr_nx  = {1'b0, lfsr_q[31:1]} ^ (lfsr_q[0] ? TAPS : 32'd0);
  assign seed_wr  = cfg_we_i && (cfg_addr_i == 3'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      decay_q   <= 32'sd58982;
      amp_q     <= 32'sd55706;
      mean_q[0] <= 32'sd183501;
      mean_q[1] <= 32'sd183501;
      mean_q[2] <= 32'sd32768;
    end else if (cfg_we_i) begin
      case (cfg_addr_i)
        3'd0: decay_q   <= cfg_data_i;
        3'd1: amp_q     <= cfg_data_i;
        3'd4: mean_q[0] <= cfg_data_i;
        3'd5: mean_q[1] <= cfg_data_i;
        3'd6: mean_q[2] <= cfg_data_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       lfsr_q <= (SEED == 32'd0) ? 32'd1 : SEED;
    else if (seed_wr) lfsr_q <= (cfg_data_i == 32'd0) ? 32'd1 : cfg_data_i;
    else if (upd_i)   lfsr_q <= lfsr_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NEURONS; i++) st_q[i] <= '0;
      cur_o     <= '0;
      cur_vld_o <= 1'b0;
    end else begin
      cur_vld_o <= upd_i;
      if (upd_i) begin
        st_q[nidx_i] <= nxt[31:0];
        cur_o        <= nxt[31:0];
      end
    end
  end
endmodule

// File: rtl/bgc_chk.sv
module bgc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        upd_i,
  input logic        cfg_we_i,
  input logic [2:0]  cfg_addr_i,
  input logic [31:0] cur_o,
  input logic        cur_vld_o,
  input logic [31:0] lfsr
);
  // R2
  vld_follows_upd_chk: assert property (@(posedge clk) disable iff (!rst_n) upd_i |=> cur_vld_o);
  // R2
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !upd_i |=> !cur_vld_o);
  // R2
  cur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !upd_i |=> $stable(cur_o));
  // R6
  lfsr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && !(cfg_we_i && cfg_addr_i == 3'd2)) |=> lfsr != $past(lfsr));
  // R6
  lfsr_rests_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_i && !(cfg_we_i && cfg_addr_i == 3'd2)) |=> $stable(lfsr));
  // R9
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n) lfsr != 32'd0);
endmodule

bind bg_current_gen bgc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .cfg_we_i(cfg_we_i),
  .cfg_addr_i(cfg_addr_i), .cur_o(cur_o), .cur_vld_o(cur_vld_o), .lfsr(lfsr_q)
);

// File: tb/sim_bg_current_gen.sv
module sim_bg_current_gen;
  localparam int N = 16;
  localparam logic [31:0] SEED = 32'hACE1_2468;
  // stimulus {index[5:2], class[1:0]}
  localparam logic [5:0] VEC [12] = '{
    6'b0000_00, 6'b0011_01, 6'b0000_00, 6'b1111_10, 6'b0101_11, 6'b0011_01,
    6'b0000_00, 6'b1111_10, 6'b0110_00, 6'b0101_10, 6'b0011_01, 6'b0000_00 };

  logic clk = 0, rst_n = 0, upd = 0, we = 0;
  logic [3:0] nidx = 0;
  logic [1:0] ncls = 0;
  logic [2:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] cur;
  logic vld;
  int checks = 0, errors = 0;
  bit done = 0;

  int lam_m = 58982, amp_m = 55706;
  int mean_m [3] = '{183501, 183501, 32768};
  int st_m [N];
  logic [31:0] lfsr_m = SEED;

  always #2 clk = ~clk;

  bg_current_gen #(.NEURONS(N), .SEED(SEED)) u0 (
    .clk(clk), .rst_n(rst_n), .upd_i(upd), .nidx_i(nidx), .ncls_i(ncls),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_data_i(wdata), .cur_o(cur), .cur_vld_o(vld));

  function automatic logic [31:0] model(int idx, int cls);
    longint m, p, q, n;
    m = (cls == 3) ? 0 : longint'(mean_m[cls]);
    p = (longint'(lam_m) * (longint'(st_m[idx]) - m)) >>> 16;
    q = (longint'(amp_m) * (longint'(lfsr_m[31:16]) - 32768)) >>> 16;
    n = m + p + q;
    st_m[idx] = int'(n);
    lfsr_m = {1'b0, lfsr_m[31:1]} ^ (lfsr_m[0] ? 32'h8020_0003 : 32'd0);
    return n[31:0];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, $signed(act), $signed(exp));
    end
  endtask

  task automatic model_cfg(logic [2:0] a, logic [31:0] d);
    case (a)
      3'd0: lam_m = d;
      3'd1: amp_m = d;
      3'd2: lfsr_m = (d == 0) ? 32'd1 : d;
      3'd4: mean_m[0] = d;
      3'd5: mean_m[1] = d;
      3'd6: mean_m[2] = d;
      default: ;
    endcase
  endtask

  task automatic cfg(logic [2:0] a, logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
    model_cfg(a, d);
  endtask

  task automatic step(int idx, int cls, string req);
    logic [31:0] e;
    @(negedge clk); upd = 1; nidx = idx[3:0]; ncls = cls[1:0];
    e = model(idx, cls);
    @(negedge clk); upd = 0;
    chk(req, cur, e);
    chk("R2 valid", {31'd0, vld}, 32'd1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    chk("R1 cur in reset", cur, 0);
    chk("R1 vld in reset", {31'd0, vld}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 cur after reset", cur, 0);
    chk("R1 vld after reset", {31'd0, vld}, 0);

    // R3 R4 R5 R6 R7: table walk, revisiting indices across classes
    for (int i = 0; i < 12; i++) step(int'(VEC[i][5:2]), int'(VEC[i][1:0]), "R3 R7 table");

    held = cur;
    @(negedge clk);
    chk("R2 hold", cur, held);
    chk("R2 idle valid", {31'd0, vld}, 0);

    // R4 R8: decay and amplitude zero give the bare class means
    cfg(3'd0, 0); cfg(3'd1, 0);
    step(1, 0, "R4 class0 mean");
    chk("R4 pyramidal 2.8", cur, 32'd183501);
    step(2, 1, "R4 class1 mean");
    chk("R4 basket 2.8", cur, 32'd183501);
    step(3, 2, "R4 class2 mean");
    chk("R4 non-basket 0.5", cur, 32'd32768);
    step(4, 3, "R4 class3 mean");
    chk("R4 class3 zero", cur, 32'd0);
    cfg(3'd6, 32'd65536);
    step(3, 2, "R8 mean write");
    chk("R8 class2 mean 1.0", cur, 32'd65536);
    cfg(3'd3, 32'd777);
    step(3, 2, "R8 unused address");

    // R9: zero seed becomes 1; amp 1.0 exposes u = -0.5
    cfg(3'd1, 32'd65536);
    cfg(3'd2, 32'd0);
    step(5, 3, "R9 zero seed");
    chk("R9 seed one gives -0.5", cur, 32'hFFFF_8000);
    cfg(3'd2, 32'hFFFF_0001);
    step(5, 3, "R9 seed load");
    chk("R5 top bits all one", cur, 32'd32767);

    // R10: write coinciding with update uses the old decay value
    cfg(3'd0, 32'd58982);
    @(negedge clk); upd = 1; nidx = 4'd6; ncls = 2'd0; we = 1; addr = 3'd0; wdata = 32'd0;
    held = model(6, 0);
    @(negedge clk); upd = 0; we = 0;
    model_cfg(3'd0, 32'd0);
    chk("R10 old decay used", cur, held);
    step(6, 0, "R10 new decay later");

    // R10: seed write overrides advance in the same cycle
    @(negedge clk); upd = 1; nidx = 4'd7; ncls = 2'd3; we = 1; addr = 3'd2; wdata = 32'h8000_0000;
    held = model(7, 3);
    @(negedge clk); upd = 0; we = 0;
    model_cfg(3'd2, 32'h8000_0000);
    chk("R10 update with old lfsr", cur, held);
    step(7, 3, "R10 seed wins over advance");
    chk("R10 seed top bits", cur, 32'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule